// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block is one general-purpose I/O port whose pins may be claimed by on-chip functions. A small register bus reaches four per-port registers: the output latch (data), the direction, the pullup enable and the slew enable. Each register holds one bit per pin. For every pin the block drives the pad controls (output enable, output value, pullup, slew) and takes back the pad's input level.

Two functions can take pins away from the registers. The debug/mode-select function owns pin 0 while it is enabled. It then sets that pin's direction and value, and the pin's pullup is forced on. The clock-generation function owns pins 1 and 2 while it is enabled, and the block leaves those pads undriven for the oscillator. While reset is held, pin 0 is a mode-select input. The block keeps the level the pin had at the last clock edge of reset and holds it on a status output until the next reset. With its function disabled, pin 0 is a plain GPIO pin and can act as an output.

Top module: `gpio_shared_port`

## Requirements
- R1: While reset is held and just after it, the data, direction, pullup and slew registers are all 0. Every pad output enable is 0, including pin 0 when the debug function is enabled.
- R2: The direction register is at offset 1, the pullup register at offset 2 and the slew register at offset 3. A write to one of them reads back at the same offset, and the slew bits appear unchanged on `pad_slew`.
- R3: At offset 0, a read returns the output latch bit for pins whose direction bit is 1 and the pad input level for pins whose direction bit is 0. A write always updates the output latch, even for an input pin.
- R4: On a GPIO pin that no function owns, a direction bit of 1 enables the output driver and a bit of 0 disables it. The pad output value equals the latch bit.
- R5: On a pin that no function owns, the pullup is on exactly when its pullup bit is 1 and its direction bit is 0. The pullup is never on while the pin drives.
- R6: While `dbg_en` is 1 and reset is released, pin 0 takes its output enable from `dbg_oe` and its value from `dbg_out`, and its pullup is on whatever the pullup and direction bits hold.
- R7: While `osc_en` is 1, pins 1 and 2 have output enable 0, output value 0 and pullup 0, whatever their register bits. Other pins are unaffected.
- R8: `mode_sel` holds the level of `pad_in[0]` at the last rising clock edge with reset held. It does not change until reset is held again.
- R9: Reads at offsets 4 to 7 return 0, and writes there change no register.
- R10: With `dbg_en` at 0, pin 0 behaves as an ordinary GPIO pin and can drive its latch value as an output.
- R11: Nothing changes when `bus_sel` is 0, even if `bus_we` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, 1 = write |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| dbg_en | input | 1 | Debug/mode-select function owns pin 0 |
| dbg_oe | input | 1 | Debug function's output enable for pin 0 |
| dbg_out | input | 1 | Debug function's output value for pin 0 |
| osc_en | input | 1 | Clock-generation function owns pins 1 and 2 |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| pad_pu | output | 8 | Pad pullup enables |
| pad_slew | output | 8 | Pad slew controls |
| mode_sel | output | 1 | Mode level captured from pin 0 during reset |

## Verification
The bench reads the data offset with mixed directions and pad levels that differ from the latch. A design that read only the latch or only the pad would return the wrong bit mix. It also writes the latch of an input pin and then turns the pin into an output, which exposes a design that drops writes to input pins. It enables the debug function with pullup bit 0 cleared and the pin set as an output. It also enables the oscillator over pins set up as outputs with pullups. A design whose override is incomplete would leak a driver or lose the forced pullup there. Finally, the bench holds pin 0 high and then low across two resets, and changes it after reset release. A latch that kept sampling, or sampled at the wrong edge, would show a mode value that follows the pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register offsets within the port window; the low two address bits select one.
    typedef enum logic [1:0] {
        OFS_LATCH = 2'd0,
        OFS_DIR   = 2'd1,
        OFS_PULL  = 2'd2,
        OFS_SLEW  = 2'd3
    } reg_ofs_e;

    localparam int unsigned OFS_BITS = 2;

    // Per-pin ownership after function overrides are resolved.
    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_DBG  = 2'd1,
        OWN_OSC  = 2'd2
    } pin_owner_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  pull_q,
    output logic [WIDTH-1:0]  slew_q
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] pull;
        logic [WIDTH-1:0] slew;
    } regs_t;

    regs_t    st_d, st_q;
    logic     in_window;
    reg_ofs_e ofs;
    logic     wr_en;

    always_comb begin
        in_window = ((bus_addr >> OFS_BITS) == '0);
        ofs       = reg_ofs_e'(bus_addr[OFS_BITS-1:0]);
        wr_en     = bus_sel && bus_we && in_window;

        st_d = st_q;
        if (wr_en) begin
            case (ofs)
                OFS_LATCH: st_d.latch = bus_wdata;
                OFS_DIR:   st_d.dir   = bus_wdata;
                OFS_PULL:  st_d.pull  = bus_wdata;
                OFS_SLEW:  st_d.slew  = bus_wdata;
                default:   st_d       = st_q;
            endcase
        end

        bus_rdata = '0;
        if (in_window) begin
            case (ofs)
                OFS_LATCH: bus_rdata = (st_q.latch & st_q.dir) | (pad_in & ~st_q.dir);
                OFS_DIR:   bus_rdata = st_q.dir;
                OFS_PULL:  bus_rdata = st_q.pull;
                OFS_SLEW:  bus_rdata = st_q.slew;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.latch;
    assign dir_q   = st_q.dir;
    assign pull_q  = st_q.pull;
    assign slew_q  = st_q.slew;

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned DBG_PIN = 0,
    parameter int unsigned OSC_LO  = 1,
    parameter int unsigned OSC_CNT = 2
) (
    input  logic             in_reset,
    input  logic             dbg_en,
    input  logic             dbg_oe,
    input  logic             dbg_out,
    input  logic             osc_en,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    localparam int unsigned OSC_HI = OSC_LO + OSC_CNT - 1;

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        localparam bit IS_DBG = (p == DBG_PIN);
        localparam bit IS_OSC = (p >= OSC_LO) && (p <= OSC_HI);

        pin_owner_e owner;
        logic       oe_d, out_d, pu_d;

        always_comb begin
            owner = OWN_GPIO;
            if (IS_DBG && dbg_en) owner = OWN_DBG;
            if (IS_OSC && osc_en) owner = OWN_OSC;

            case (owner)
                OWN_DBG: begin
                    oe_d  = dbg_oe;
                    out_d = dbg_out;
                    pu_d  = 1'b1;
                end
                OWN_OSC: begin
                    oe_d  = 1'b0;
                    out_d = 1'b0;
                    pu_d  = 1'b0;
                end
                default: begin
                    oe_d  = dir_q[p];
                    out_d = latch_q[p];
                    pu_d  = pull_q[p] & ~dir_q[p];
                end
            endcase

            // During reset the mode-select pin is always an input.
            if (IS_DBG && in_reset) oe_d = 1'b0;
        end

        assign pad_oe[p]  = oe_d;
        assign pad_out[p] = out_d;
        assign pad_pu[p]  = pu_d;
    end

endmodule

// File: rtl/gpio_mode_latch.sv
module gpio_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic mode_q
);

    logic mode_d;

    // Track the pin on every edge while reset is held; freeze once released.
    always_comb begin
        mode_d = rst_n ? mode_q : pin_in;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned DBG_PIN = 0,
    parameter int unsigned OSC_LO  = 1,
    parameter int unsigned OSC_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              dbg_en,
    input  logic              dbg_oe,
    input  logic              dbg_out,
    input  logic              osc_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu,
    output logic [WIDTH-1:0]  pad_slew,
    output logic              mode_sel
);

    logic [WIDTH-1:0] latch_q, dir_q, pull_q, slew_q;
    logic             in_reset;

    assign in_reset = ~rst_n;

    gpio_port_regs #(
        .WIDTH  (WIDTH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pad_in    (pad_in),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pull_q    (pull_q),
        .slew_q    (slew_q)
    );

    gpio_pin_ctrl #(
        .WIDTH   (WIDTH),
        .DBG_PIN (DBG_PIN),
        .OSC_LO  (OSC_LO),
        .OSC_CNT (OSC_CNT)
    ) u_pins (
        .in_reset (in_reset),
        .dbg_en   (dbg_en),
        .dbg_oe   (dbg_oe),
        .dbg_out  (dbg_out),
        .osc_en   (osc_en),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pull_q   (pull_q),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu)
    );

    gpio_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pad_in[DBG_PIN]),
        .mode_q (mode_sel)
    );

    assign pad_slew = slew_q;

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
    parameter int unsigned WIDTH   = 8,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned DBG_PIN = 0,
    parameter int unsigned OSC_LO  = 1,
    parameter int unsigned OSC_CNT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              dbg_en,
    input logic              osc_en,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic [WIDTH-1:0]  pad_slew,
    input logic              mode_sel
);

    localparam logic [WIDTH-1:0] OSC_MASK = ((WIDTH'(1) << OSC_CNT) - WIDTH'(1)) << OSC_LO;
    localparam logic [WIDTH-1:0] DBG_MASK = WIDTH'(1) << DBG_PIN;
    localparam logic [WIDTH-1:0] FREE_MASK = ~(OSC_MASK | DBG_MASK);

    assert_no_drive_pull_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe & FREE_MASK) == '0));

    assert_dbg_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_en |-> pad_pu[DBG_PIN]);

    assert_osc_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |-> (((pad_oe | pad_pu) & OSC_MASK) == '0));

    assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_sel));

    assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && ((bus_addr >> 2) != '0)) |-> (bus_rdata == '0));

    assert_unselected_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(pad_slew));

endmodule

bind gpio_shared_port gpio_port_checker #(
    .WIDTH   (WIDTH),
    .ADDR_W  (ADDR_W),
    .DBG_PIN (DBG_PIN),
    .OSC_LO  (OSC_LO),
    .OSC_CNT (OSC_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .dbg_en    (dbg_en),
    .osc_en    (osc_en),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_slew  (pad_slew),
    .mode_sel  (mode_sel)
);

// File: tb/gpio_shared_port_tb.sv
`timescale 1ns/1ps
module gpio_shared_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dbg_en = 1'b0;
    logic       dbg_oe = 1'b0;
    logic       dbg_out = 1'b0;
    logic       osc_en = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_slew;
    logic       mode_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_shared_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_en    (dbg_en),
        .dbg_oe    (dbg_oe),
        .dbg_out   (dbg_out),
        .osc_en    (osc_en),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu),
        .pad_slew  (pad_slew),
        .mode_sel  (mode_sel)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(negedge clk);
        bus_sel = sel; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset(input logic pin0);
        @(negedge clk);
        pad_in[0] = pin0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        dbg_en = 1'b1; dbg_oe = 1'b1;
        @(negedge clk);
        pad_in[0] = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 pad_oe during reset with debug on", pad_oe, 8'h00);
        rst_n = 1'b1;
        dbg_en = 1'b0; dbg_oe = 1'b0;
        @(negedge clk);
        chk("R1 pad_oe after reset", pad_oe, 8'h00);
        chk("R1 pad_slew after reset", pad_slew, 8'h00);
        rd(3'd1, v); chk("R1 dir reg", v, 8'h00);
        rd(3'd2, v); chk("R1 pull reg", v, 8'h00);
        wr(3'd1, 8'hFF); rd(3'd0, v); chk("R1 latch reg", v, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_regs_R2();
        logic [7:0] v;
        wr(3'd1, 8'h5A); rd(3'd1, v); chk("R2 dir readback", v, 8'h5A);
        wr(3'd2, 8'hC3); rd(3'd2, v); chk("R2 pull readback", v, 8'hC3);
        wr(3'd3, 8'h96); rd(3'd3, v); chk("R2 slew readback", v, 8'h96);
        chk("R2 slew to pads", pad_slew, 8'h96);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_data_read_R3();
        logic [7:0] v;
        pad_in = 8'hA5;
        wr(3'd0, 8'h3C);
        wr(3'd1, 8'h0F);
        rd(3'd0, v); chk("R3 mixed read", v, 8'hAC);
        pad_in = 8'h5A;
        rd(3'd0, v); chk("R3 mixed read new pad", v, 8'h5C);
        wr(3'd0, 8'hF0);
        wr(3'd1, 8'hFF);
        rd(3'd0, v); chk("R3 latch written while input", v, 8'hF0);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_gpio_pins_R4();
        wr(3'd0, 8'h69);
        wr(3'd1, 8'hF8);
        chk("R4 pad_oe", pad_oe, 8'hF8);
        chk("R4 pad_out", pad_out, 8'h69);
        wr(3'd1, 8'h00);
        chk("R4 pad_oe cleared", pad_oe, 8'h00);
    endtask

    task automatic t_pullup_R5();
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'h33);
        chk("R5 pullup masked by output", pad_pu, 8'hCC);
        wr(3'd2, 8'h0F);
        chk("R5 pullup subset", pad_pu, 8'h0C);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_debug_R6();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h01);
        @(negedge clk);
        dbg_en = 1'b1; dbg_oe = 1'b0; dbg_out = 1'b1;
        #1;
        chk("R6 debug input oe", pad_oe & 8'h01, 8'h00);
        chk("R6 forced pullup", pad_pu & 8'h01, 8'h01);
        dbg_oe = 1'b1;
        #1;
        chk("R6 debug drives", {6'd0, pad_oe[0], pad_out[0]}, 8'h03);
        @(negedge clk);
        dbg_en = 1'b0; dbg_oe = 1'b0; dbg_out = 1'b0;
        wr(3'd1, 8'h00);
    endtask

    task automatic t_osc_R7();
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hF6);
        wr(3'd2, 8'hFF);
        @(negedge clk);
        osc_en = 1'b1;
        #1;
        chk("R7 osc pins oe", pad_oe, 8'hF0);
        chk("R7 osc pins out", pad_out, 8'hF9);
        chk("R7 osc pins pullup", pad_pu, 8'h09);
        @(negedge clk);
        osc_en = 1'b0;
        #1;
        chk("R7 release restores gpio", pad_oe, 8'hF6);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h00);
    endtask

    task automatic t_mode_R8();
        do_reset(1'b1);
        chk("R8 mode high captured", {7'd0, mode_sel}, 8'h01);
        pad_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 mode held after pin change", {7'd0, mode_sel}, 8'h01);
        do_reset(1'b0);
        chk("R8 mode low captured", {7'd0, mode_sel}, 8'h00);
        pad_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 mode held low", {7'd0, mode_sel}, 8'h00);
        pad_in = 8'h00;
    endtask

    task automatic t_hole_R9();
        logic [7:0] v;
        wr(3'd3, 8'h11);
        for (int a = 4; a < 8; a++) begin
            wr(3'(a), 8'hEE);
            rd(3'(a), v); chk("R9 hole reads zero", v, 8'h00);
        end
        rd(3'd3, v); chk("R9 slew untouched", v, 8'h11);
        rd(3'd1, v); chk("R9 dir untouched", v, 8'h00);
        rd(3'd2, v); chk("R9 pull untouched", v, 8'h00);
    endtask

    task automatic t_pin0_gpio_R10();
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h01);
        chk("R10 pin0 output", {6'd0, pad_oe[0], pad_out[0]}, 8'h03);
        wr(3'd0, 8'h00);
        chk("R10 pin0 drives low", {6'd0, pad_oe[0], pad_out[0]}, 8'h02);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_nosel_R11();
        logic [7:0] v;
        wr(3'd3, 8'h77, 1'b0);
        chk("R11 slew unchanged", pad_slew, 8'h11);
        wr(3'd1, 8'hFF, 1'b0);
        chk("R11 oe unchanged", pad_oe, 8'h00);
        rd(3'd1, v); chk("R11 dir unchanged", v, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_regs_R2();
        t_data_read_R3();
        t_gpio_pins_R4();
        t_pullup_R5();
        t_debug_R6();
        t_osc_R7();
        t_hole_R9();
        t_nosel_R11();
        t_pin0_gpio_R10();
        t_mode_R8();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule